// File: doc/BRIEF.md
# 2D Rectangle Fill and Copy Engine

This block is a small drawing accelerator for a linear framebuffer. A host streams 32-bit command words into an internal command queue. The engine decodes three kinds of command: a pixel-format setup, a solid rectangle fill and a screen-to-screen rectangle copy. It walks the target rectangle one pixel at a time and issues single-pixel transactions on a request/acknowledge memory port. A configuration register file holds the framebuffer base, the line pitch in pixels, the foreground colour and a destination clip window. A status word tells the host when all queued work has drained.

The command input is a valid/ready stream. A word transfers on a rising clock edge where both `cmd_valid` and `cmd_ready` are high. `cmd_ready` falls only when the queue is full. While it is low, the host keeps `cmd_data` stable and holds `cmd_valid`. `free_slots` reports the room left in the queue, so software can wait until a whole command fits. Coordinates are packed with y in bits 31:16 and x in bits 15:0.

On the memory side the engine raises `mem_req` and holds it until `mem_ack`. For a copy, each pixel is read from the source and then written to the destination before the walker moves on.

Top module: `blit2d_engine`

## Requirements
- R1: `cmd_ready` is low only when the queue holds DEPTH words. `free_slots` equals DEPTH minus the number of words held, and a push and a pop in the same cycle leave it unchanged. Nothing accepted is lost.
- R2: Fill command. The host sends the word 0x09410000, then an origin word {y,x}, then a size word {height,width}. The engine writes the foreground colour (config index 2) to every pixel of the rectangle that lies inside the clip window.
- R3: Copy command. The host sends 0x0d000000 with bits 23:16 set to a direction code 0x44–0x47, then a source word, a destination word and a size word, each {y,x}. After the copy, every in-clip destination pixel holds the value its source pixel had before the command started. This holds when the rectangles overlap, provided the direction code follows R4.
- R4: Bit 16 of the copy command walks x from the right edge downward. Bit 17 walks y from the bottom row upward. The host sets bit 16 when source x < destination x and bit 17 when source y < destination y. Any copy word whose bits 23:18 differ from 010001, or whose bits 15:0 are not zero, is an unknown opcode.
- R5: The setup command is 0xf1010108 followed by one word. Bit 15 of that word selects 16-bit pixels when set and 8-bit pixels when clear. After reset the engine uses 8-bit pixels.
- R6: A destination pixel is accessed only when x is within [xmin, xmax] and y is within [ymin, ymax] (config indices 4–7, both bounds inclusive). A skipped copy pixel causes neither a read nor a write.
- R7: A fill or copy with zero width or zero height completes without any memory transaction.
- R8: An unknown opcode word is dropped on its own and sets sticky status bit 12. The next word is decoded as a new command.
- R9: Status bit 0 means the queue is not empty. Bit 4 means a command is being decoded or run. Bit 5 means the pixel walker is active. Bit 8 means a memory request is open. The status AND 0x131 is nonzero until every queued command has finished, and is zero after reset.
- R10: A pixel's address is base + (y·pitch + x)·bytes-per-pixel. `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` stay stable from request until the acknowledge cycle.
- R11: In 8-bit mode, fill data and copied data carry only their low byte; bits 15:8 of `mem_wdata` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command word offered |
| cmd_ready | output | 1 | Queue can take a word |
| cmd_data | input | 32 | Command or operand word |
| free_slots | output | FW | Empty queue entries |
| cfg_we | input | 1 | Config register write strobe |
| cfg_sel | input | 3 | 0 base, 1 pitch, 2 fg colour, 3 bg colour, 4 xmin, 5 xmax, 6 ymin, 7 ymax |
| cfg_wdata | input | 32 | Config write data |
| status | output | 16 | Busy bits 0/4/5/8, error bit 12 |
| mem_req | output | 1 | Pixel transaction request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | AW | Byte address of pixel |
| mem_wdata | output | 16 | Write pixel |
| mem_rdata | input | 16 | Read pixel, valid with ack |
| mem_ack | input | 1 | Transaction complete |

## Verification
Two things can happen in the same cycle: the host can push into the queue while the decoder pops from it, and the host can keep enqueuing while the walker is still drawing. The bench provokes both by holding the memory acknowledge off while a fill is running. It then streams further commands until the queue is full, which it judges from `free_slots` reaching zero and `cmd_ready` falling. It then releases the acknowledge, so the last word is pushed while earlier words drain. It judges the outcome from the final memory image, which is computed arithmetically for every queued rectangle, and from the free count returning to DEPTH. Overlapping copies are swept over a 5×5 grid of displacements, and each result is compared with a copy taken from a snapshot of memory.

// File: rtl/blit2d_pkg.sv
package blit2d_pkg;
  localparam logic [31:0] OP_FILL = 32'h0941_0000;
  localparam logic [31:0] OP_MODE = 32'hf101_0108;

  typedef struct packed {
    logic [15:0] y;
    logic [15:0] x;
  } xy_t;

  typedef enum logic [1:0] {D_IDLE, D_ARGS, D_RUN} dec_st_t;
  typedef enum logic [1:0] {K_FILL, K_BLIT, K_MODE} kind_t;
  typedef enum logic [1:0] {W_IDLE, W_EVAL, W_RD, W_WR} walk_st_t;
endpackage

// File: rtl/blit2d_fifo.sv
module blit2d_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 32,
  parameter int FW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [W-1:0]  in_data,
  output logic          out_valid,
  input  logic          out_pop,
  output logic [W-1:0]  out_data,
  output logic [FW-1:0] free_slots
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  store [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [FW-1:0] cnt;
  logic          push, pop;

  assign in_ready   = (cnt != FW'(DEPTH));
  assign out_valid  = (cnt != '0);
  assign out_data   = store[rp];
  assign free_slots = FW'(DEPTH) - cnt;
  assign push       = in_valid && in_ready;
  assign pop        = out_pop && out_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) begin
        store[wp] <= in_data;
        wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      end
      if (pop) rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  p_no_overflow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FW'(DEPTH));
  p_pushpop_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop) |=> $stable(free_slots));
endmodule

// File: rtl/blit2d_walker.sv
module blit2d_walker
  import blit2d_pkg::*;
#(
  parameter int AW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          is_blit,
  input  logic          dec_x,
  input  logic          dec_y,
  input  xy_t           src_i,
  input  xy_t           dst_i,
  input  xy_t           size_i,
  input  logic [AW-1:0] base,
  input  logic [15:0]   pitch,
  input  logic [15:0]   fg,
  input  logic          pix16,
  input  logic [15:0]   xmin,
  input  logic [15:0]   xmax,
  input  logic [15:0]   ymin,
  input  logic [15:0]   ymax,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [15:0]   mem_wdata,
  input  logic [15:0]   mem_rdata,
  input  logic          mem_ack,
  output logic          busy
);
  walk_st_t    st;
  xy_t         src_q, dst_q, size_q;
  logic        blit_q, decx_q, decy_q;
  logic [15:0] ox, oy, pix_q;
  logic [15:0] offx, offy, px, py, qx, qy;
  logic        inclip, last_x, last_y, step;

  function automatic logic [AW-1:0] pix_addr(input logic [15:0] x, input logic [15:0] y);
    logic [31:0] lin;
    lin = 32'(y) * 32'(pitch) + 32'(x);
    return base + AW'(pix16 ? (lin << 1) : lin);
  endfunction

  always_comb begin
    offx   = decx_q ? (size_q.x - 16'd1 - ox) : ox;
    offy   = decy_q ? (size_q.y - 16'd1 - oy) : oy;
    px     = dst_q.x + offx;
    py     = dst_q.y + offy;
    qx     = src_q.x + offx;
    qy     = src_q.y + offy;
    inclip = (px >= xmin) && (px <= xmax) && (py >= ymin) && (py <= ymax);
    last_x = (ox == size_q.x - 16'd1);
    last_y = (oy == size_q.y - 16'd1);
    step   = ((st == W_EVAL) && !inclip) || ((st == W_WR) && mem_ack);
  end

  assign busy      = (st != W_IDLE);
  assign mem_req   = (st == W_RD) || (st == W_WR);
  assign mem_we    = (st == W_WR);
  assign mem_addr  = (st == W_RD) ? pix_addr(qx, qy) : pix_addr(px, py);
  assign mem_wdata = blit_q ? pix_q : (pix16 ? fg : {8'h00, fg[7:0]});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= W_IDLE;
      src_q <= '0; dst_q <= '0; size_q <= '0;
      blit_q <= 1'b0; decx_q <= 1'b0; decy_q <= 1'b0;
      ox <= '0; oy <= '0; pix_q <= '0;
    end else begin
      case (st)
        W_IDLE: if (start) begin
          src_q <= src_i; dst_q <= dst_i; size_q <= size_i;
          blit_q <= is_blit; decx_q <= dec_x; decy_q <= dec_y;
          ox <= '0; oy <= '0;
          if (size_i.x != '0 && size_i.y != '0) st <= W_EVAL;
        end
        W_EVAL: if (inclip) st <= blit_q ? W_RD : W_WR;
        W_RD: if (mem_ack) begin
          pix_q <= pix16 ? mem_rdata : {8'h00, mem_rdata[7:0]};
          st <= W_WR;
        end
        default: ;
      endcase
      if (step) begin
        if (last_x) begin
          ox <= '0;
          if (last_y) st <= W_IDLE;
          else begin oy <= oy + 16'd1; st <= W_EVAL; end
        end else begin
          ox <= ox + 16'd1;
          st <= W_EVAL;
        end
      end
    end
  end

  p_clip_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (px >= xmin && px <= xmax && py >= ymin && py <= ymax));
  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata)));
  p_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == W_IDLE && start && (size_i.x == '0 || size_i.y == '0)) |=> !busy);
  p_byte_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && !pix16) |-> (mem_wdata[15:8] == 8'h00));
endmodule

// File: rtl/blit2d_engine.sv
module blit2d_engine
  import blit2d_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 24,
  parameter int FW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [31:0]   cmd_data,
  output logic [FW-1:0] free_slots,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_sel,
  input  logic [31:0]   cfg_wdata,
  output logic [15:0]   status,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [15:0]   mem_wdata,
  input  logic [15:0]   mem_rdata,
  input  logic          mem_ack
);
  localparam int NCFG = 8;

  logic [31:0] cfg_q [NCFG];
  logic        f_valid, f_pop;
  logic [31:0] w;
  dec_st_t     d_st;
  kind_t       kind;
  logic [1:0]  need, idx, dir_q;
  xy_t         arg_q [3];
  logic        start_q, pix16, err, w_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCFG; i++)
        cfg_q[i] <= (i == 5 || i == 7) ? 32'h0000_ffff : 32'h0;
    end else if (cfg_we) begin
      cfg_q[cfg_sel] <= cfg_wdata;
    end
  end

  blit2d_fifo #(.DEPTH(DEPTH), .W(32), .FW(FW)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .in_valid(cmd_valid), .in_ready(cmd_ready), .in_data(cmd_data),
    .out_valid(f_valid), .out_pop(f_pop), .out_data(w),
    .free_slots(free_slots)
  );

  assign f_pop = f_valid && (d_st != D_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d_st <= D_IDLE; kind <= K_FILL; need <= '0; idx <= '0; dir_q <= '0;
      start_q <= 1'b0; pix16 <= 1'b0; err <= 1'b0;
      for (int i = 0; i < 3; i++) arg_q[i] <= '0;
    end else begin
      start_q <= 1'b0;
      case (d_st)
        D_IDLE: if (f_valid) begin
          idx <= '0;
          if (w == OP_FILL) begin
            kind <= K_FILL; need <= 2'd2; d_st <= D_ARGS;
          end else if (w[31:24] == 8'h0d && w[23:18] == 6'b010001 && w[15:0] == 16'h0) begin
            kind <= K_BLIT; need <= 2'd3; dir_q <= w[17:16]; d_st <= D_ARGS;
          end else if (w == OP_MODE) begin
            kind <= K_MODE; need <= 2'd1; d_st <= D_ARGS;
          end else begin
            err <= 1'b1;
          end
        end
        D_ARGS: if (f_valid) begin
          arg_q[idx] <= w;
          idx <= idx + 2'd1;
          if (idx == need - 2'd1) begin
            if (kind == K_MODE) begin
              pix16 <= w[15];
              d_st <= D_IDLE;
            end else begin
              start_q <= 1'b1;
              d_st <= D_RUN;
            end
          end
        end
        D_RUN: if (!start_q && !w_busy) d_st <= D_IDLE;
        default: d_st <= D_IDLE;
      endcase
    end
  end

  blit2d_walker #(.AW(AW)) u_walk (
    .clk(clk), .rst_n(rst_n), .start(start_q),
    .is_blit(kind == K_BLIT), .dec_x(dir_q[0]), .dec_y(dir_q[1]),
    .src_i(arg_q[0]),
    .dst_i((kind == K_BLIT) ? arg_q[1] : arg_q[0]),
    .size_i((kind == K_BLIT) ? arg_q[2] : arg_q[1]),
    .base(cfg_q[0][AW-1:0]), .pitch(cfg_q[1][15:0]), .fg(cfg_q[2][15:0]),
    .pix16(pix16),
    .xmin(cfg_q[4][15:0]), .xmax(cfg_q[5][15:0]),
    .ymin(cfg_q[6][15:0]), .ymax(cfg_q[7][15:0]),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .busy(w_busy)
  );

  always_comb begin
    status     = '0;
    status[0]  = f_valid;
    status[4]  = (d_st != D_IDLE);
    status[5]  = w_busy;
    status[8]  = mem_req;
    status[12] = err;
  end

  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (d_st == D_IDLE) |-> !mem_req);
endmodule

// File: tb/test_blit2d_engine.sv
module test_blit2d_engine;
  localparam int DEPTH = 8;
  localparam int AW    = 24;
  localparam int FW    = 4;
  localparam int BASE  = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_ready;
  logic [31:0] cmd_data = '0;
  logic [FW-1:0] free_slots;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic [15:0] status;
  logic mem_req, mem_we, mem_ack;
  logic [AW-1:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata;

  logic [15:0] mem  [1024];
  logic [15:0] refm [1024];
  logic [15:0] snap [1024];
  int nchk = 0, nfail = 0, wr_cnt = 0, rd_cnt = 0, dly = 0;
  logic stall = 1'b0;
  int cxmin = 0, cxmax = 15, cymin = 0, cymax = 15;
  bit pix16 = 1'b0;

  always #2 clk = ~clk;

  blit2d_engine #(.DEPTH(DEPTH), .AW(AW)) i_blit2d_engine (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_data(cmd_data), .free_slots(free_slots), .cfg_we(cfg_we),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .status(status),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 1024; i++) mem[i] <= 16'(i * 37) ^ 16'h5a5a;
      mem_ack <= 1'b0; mem_rdata <= '0; dly <= 0;
    end else begin
      mem_ack <= 1'b0;
      if (mem_req && !mem_ack && !stall) begin
        if (dly >= 1) begin
          mem_ack <= 1'b1; dly <= 0;
          if (mem_we) begin mem[mem_addr[9:0]] <= mem_wdata; wr_cnt <= wr_cnt + 1; end
          else begin mem_rdata <= mem[mem_addr[9:0]]; rd_cnt <= rd_cnt + 1; end
        end else dly <= dly + 1;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", nchk + 1, nfail + 1);
    $finish;
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic push(input logic [31:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_data = d;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic cfg(input int sel, input int val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 3'(sel); cfg_wdata = 32'(val);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_clip(input int a, input int b, input int c, input int d);
    cfg(4, a); cfg(5, b); cfg(6, c); cfg(7, d);
    cxmin = a; cxmax = b; cymin = c; cymax = d;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while ((status & 16'h0131) != 16'h0);
  endtask

  function automatic int paddr(input int x, input int y);
    return BASE + (pix16 ? (y * 16 + x) * 2 : (y * 16 + x));
  endfunction

  function automatic bit inclip(input int x, input int y);
    return x >= cxmin && x <= cxmax && y >= cymin && y <= cymax;
  endfunction

  function automatic int ref_fill(input int x0, input int y0, input int w, input int h, input int col);
    int n = 0;
    for (int j = 0; j < h; j++)
      for (int i = 0; i < w; i++)
        if (inclip(x0 + i, y0 + j)) begin
          refm[paddr(x0 + i, y0 + j)] = pix16 ? 16'(col) : 16'(col & 255);
          n++;
        end
    return n;
  endfunction

  task automatic cmp_mem(input string req);
    int bad = 0;
    for (int i = 0; i < 1024; i++) if (mem[i] !== refm[i]) bad++;
    check(bad == 0, req, "mismatching memory words", bad, 0);
  endtask

  task automatic do_fill(input int x0, input int y0, input int w, input int h, input int col, input string req);
    int w0, n;
    cfg(2, col);
    w0 = wr_cnt;
    push(32'h0941_0000);
    push({16'(y0), 16'(x0)});
    push({16'(h), 16'(w)});
    wait_idle();
    n = ref_fill(x0, y0, w, h, col);
    cmp_mem(req);
    check(wr_cnt - w0 == n, req, "write count", wr_cnt - w0, n);
  endtask

  task automatic do_blit(input int sx, input int sy, input int dx, input int dy, input int w, input int h, input string req);
    int r0, n;
    logic [31:0] op;
    r0 = rd_cnt; n = 0;
    op = 32'h0d44_0000 | ((sy < dy) ? 32'h0002_0000 : 0) | ((sx < dx) ? 32'h0001_0000 : 0);
    push(op);
    push({16'(sy), 16'(sx)});
    push({16'(dy), 16'(dx)});
    push({16'(h), 16'(w)});
    wait_idle();
    for (int i = 0; i < 1024; i++) snap[i] = refm[i];
    for (int j = 0; j < h; j++)
      for (int i = 0; i < w; i++)
        if (inclip(dx + i, dy + j)) begin
          refm[paddr(dx + i, dy + j)] = snap[paddr(sx + i, sy + j)];
          n++;
        end
    cmp_mem(req);
    check(rd_cnt - r0 == n, req, "read count", rd_cnt - r0, n);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) refm[i] = 16'(i * 37) ^ 16'h5a5a;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state, R1 empty queue
    check(status == 16'h0, "R9", "status after reset", status, 0);
    check(free_slots == 4'(DEPTH), "R1", "free slots after reset", free_slots, DEPTH);
    check(cmd_ready && !mem_req, "R1", "ready and idle port", {cmd_ready, mem_req}, 2);

    cfg(0, BASE); cfg(1, 16);
    set_clip(0, 15, 0, 15);
    // R5 select 16-bit pixels
    push(32'hf101_0108); push(32'h0000_8000); pix16 = 1'b1;
    wait_idle();

    // R2 R10 fills at several origins and sizes
    for (int k = 0; k < 6; k++) do_fill(k, k, 3 + k, 2 + (k % 3), 16'h1000 + k * 111, "R2");

    // R6 clipped fill
    set_clip(3, 10, 2, 9);
    do_fill(0, 0, 16, 16, 16'h7777, "R6");
    set_clip(0, 15, 0, 15);

    // R7 empty rectangles
    do_fill(4, 4, 0, 5, 16'h3333, "R7");
    do_fill(4, 4, 5, 0, 16'h3333, "R7");

    // R3 R4 overlapping copy sweep
    for (int dyo = -2; dyo <= 2; dyo++)
      for (int dxo = -2; dxo <= 2; dxo++)
        do_blit(6, 6, 6 + dxo, 6 + dyo, 4, 3, "R3_R4");

    // R6 clipped copy
    set_clip(7, 8, 0, 15);
    do_blit(4, 4, 6, 5, 4, 4, "R6");
    set_clip(0, 15, 0, 15);

    // R8 unknown opcode
    check(status[12] == 1'b0, "R8", "error bit before", status[12], 0);
    push(32'hdead_beef);
    push(32'h0d48_0000);
    do_fill(1, 12, 2, 2, 16'h4242, "R8");
    check(status[12] == 1'b1, "R8", "error bit after", status[12], 1);

    // R5 R11 byte pixels
    push(32'hf101_0108); push(32'h0000_0000); pix16 = 1'b0;
    wait_idle();
    do_fill(2, 1, 3, 1, 16'hABCD, "R11");
    do_blit(2, 1, 3, 2, 3, 1, "R11");
    push(32'hf101_0108); push(32'h0000_8000); pix16 = 1'b1;
    wait_idle();

    // R1 R9 queue fills while the walker is stalled
    cfg(2, 16'h0bad);
    stall = 1'b1;
    for (int k = 0; k < 4; k++) begin
      push(32'h0941_0000);
      push({16'(14), 16'(k * 4)});
      if (k < 3) push({16'(2), 16'(3)});
    end
    @(negedge clk);
    check(free_slots == 0, "R1", "free slots when full", free_slots, 0);
    check(!cmd_ready, "R1", "ready when full", cmd_ready, 0);
    check((status & 16'h0131) != 0, "R9", "busy while stalled", status, 16'h0131);
    stall = 1'b0;
    push({16'(2), 16'(3)});
    wait_idle();
    for (int k = 0; k < 4; k++) void'(ref_fill(k * 4, 14, 3, 2, 16'h0bad));
    cmp_mem("R1");
    check(free_slots == 4'(DEPTH), "R1", "free slots drained", free_slots, DEPTH);
    check((status & 16'h0131) == 0, "R9", "idle after drain", status, 0);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule